// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block builds the byte that a flash-style memory returns on a read while an internal program or erase sequence is running, and while an erase is paused. The value depends on three things: whether the operation is a program or an erase, whether the read address falls in a sector marked for erasure, and how many status reads came before it. Two of the bits flip from one read to the next, so a host can poll and tell when the operation has finished.

When no operation is busy and nothing is suspended, the block passes the array byte through unchanged. During a suspend, reads of sectors that are not marked for erasure also return array data. Reads of marked sectors return a suspend status byte. Command decoding and the array storage sit outside this block. The output is registered: it is loaded on the clock edge that samples a read strobe and holds until the next strobe.

Top module: `status_gen`

## Requirements
- R1: After reset, `rd_data` is 8'h00, and both toggle states start at 0, so the first qualifying read shows 0 in bit 6 and in bit 2.
- R2: `rd_data` changes only on the clock edge that samples `rd_stb` high, and holds its value in every other cycle.
- R3: With `busy` and `susp` both low, a read returns `array_data` unchanged.
- R4: While a program is busy (`busy`=1, `susp`=0, `op_erase`=0), bit 7 returns the inverse of `tgt_data[7]`. Bits 3 and 2 read 0.
- R5: While an erase is busy (`op_erase`=1), bit 7 reads 0.
- R6: Each read taken while `busy`=1 and `susp`=0 returns the current bit-6 toggle state, and the read then inverts that state. Other reads leave the state unchanged.
- R7: While `busy`=1 and `susp`=0, bit 5 returns `over_time`.
- R8: While an erase is busy, bit 3 reads 1 when `accept_open` is low (the sector acceptance window has closed) and 0 when it is high.
- R9: The sector index is the top log2(NSECT) bits of `rd_addr`, and a sector counts as selected when `sect_sel` has a 1 at that index. During a busy erase or a suspend, bit 2 returns the bit-2 toggle state. Only reads of selected sectors invert that state; reads of other sectors show the held value.
- R10: While `susp`=1, a read of a selected sector returns bit 7 = 1, bit 6 = the held bit-6 state, bit 2 = the bit-2 state, and 0 in every other bit. A read of any other sector returns `array_data`.
- R11: While `busy`=1 and `susp`=0, bits 4, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Embedded operation running |
| susp | input | 1 | Erase suspended |
| op_erase | input | 1 | 1 = erase, 0 = program |
| tgt_data | input | 8 | Byte being programmed |
| sect_sel | input | NSECT | Sectors marked for erasure |
| accept_open | input | 1 | Sector acceptance window still open |
| over_time | input | 1 | Operation exceeded its time limit |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| array_data | input | 8 | Array byte at the read address |
| rd_data | output | 8 | Returned byte |

## Verification
Every result appears in the cycle after the edge that samples the strobe. The bench loads its expected byte one time unit after that edge, then compares on every clock after that edge has settled. This timing also covers the cycles between reads, where the value must hold. The model uses two counters, one for each toggle. Consecutive strobes test that bit 6 and bit 2 flip every cycle, and interleaved reads of selected and unselected sectors test that bit 2 advances only on selected reads.

// File: rtl/status_gen.sv
module status_gen #(
  parameter int AW    = 19,
  parameter int NSECT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             susp,
  input  logic             op_erase,
  input  logic [7:0]       tgt_data,
  input  logic [NSECT-1:0] sect_sel,
  input  logic             accept_open,
  input  logic             over_time,
  input  logic             rd_stb,
  input  logic [AW-1:0]    rd_addr,
  input  logic [7:0]       array_data,
  output logic [7:0]       rd_data
);
  localparam int SW = $clog2(NSECT);

  logic [SW-1:0] sidx;
  logic          hit, active, zone2;
  logic          tog6, tog2;
  logic [7:0]    run_byte, sus_byte, next_byte;

  assign sidx   = rd_addr[AW-1 -: SW];
  assign hit    = sect_sel[sidx];
  assign active = busy & ~susp;
  assign zone2  = hit & (susp | (active & op_erase));

  assign run_byte = {op_erase ? 1'b0 : ~tgt_data[7], tog6, over_time, 1'b0,
                     op_erase & ~accept_open, op_erase & tog2, 2'b00};
  assign sus_byte = {1'b1, tog6, 3'b000, tog2, 2'b00};

  always_comb begin
    if (active)          next_byte = run_byte;
    else if (susp & hit) next_byte = sus_byte;
    else                 next_byte = array_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
      tog6    <= 1'b0;
      tog2    <= 1'b0;
    end else if (rd_stb) begin
      rd_data <= next_byte;
      if (active) tog6 <= ~tog6;
      if (zone2)  tog2 <= ~tog2;
    end
  end
endmodule

module status_gen_chk #(
  parameter int AW    = 19,
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             susp,
  input logic             op_erase,
  input logic [7:0]       tgt_data,
  input logic             over_time,
  input logic             rd_stb,
  input logic [7:0]       array_data,
  input logic [7:0]       rd_data
);
  logic act;
  assign act = busy & ~susp;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  // R3
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy && !susp) |=> rd_data == $past(array_data));
  // R4
  prog_d7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && act && !op_erase) |=> rd_data[7] == ~$past(tgt_data[7]));
  // R5
  erase_d7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && act && op_erase) |=> !rd_data[7]);
  // R6
  tog6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && act && $past(rd_stb && act)) |=> rd_data[6] != $past(rd_data[6]));
  // R7
  late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && act) |=> rd_data[5] == $past(over_time));
  // R11
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && act) |=> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

bind status_gen status_gen_chk #(.AW(AW), .NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .susp(susp), .op_erase(op_erase),
  .tgt_data(tgt_data), .over_time(over_time), .rd_stb(rd_stb),
  .array_data(array_data), .rd_data(rd_data));

// File: tb/status_gen_bench.sv
module status_gen_bench;
  localparam int AW = 19;
  localparam int NSECT = 8;
  localparam int SECT_SPAN = 1 << (AW - 3);

  logic clk = 0, rst_n = 0;
  logic busy = 0, susp = 0, op_erase = 0, accept_open = 1, over_time = 0, rd_stb = 0;
  logic [7:0] tgt_data = 0, array_data = 0;
  logic [NSECT-1:0] sect_sel = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int n6 = 0, n2 = 0;
  logic [7:0] exp_q = 8'h00;
  logic mon_on = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  status_gen #(.AW(AW), .NSECT(NSECT)) u_status_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .susp(susp), .op_erase(op_erase),
    .tgt_data(tgt_data), .sect_sel(sect_sel), .accept_open(accept_open),
    .over_time(over_time), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .array_data(array_data), .rd_data(rd_data));

  task automatic check(input logic [7:0] got, input logic [7:0] want, input string t);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", t, got, want, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) check(rd_data, exp_q, tag);
  end

  task automatic rd(input int sect, input string t);
    logic [7:0] e;
    bit sel, run;
    @(negedge clk);
    rd_addr = AW'(sect * SECT_SPAN + 16'h1234);
    rd_stb = 1;
    sel = sect_sel[sect];
    run = busy && !susp;
    e = array_data;
    if (run) begin
      e = 8'h00;
      e[7] = op_erase ? 1'b0 : ~tgt_data[7];
      e[6] = n6[0];
      e[5] = over_time;
      e[3] = op_erase && !accept_open;
      e[2] = op_erase ? n2[0] : 1'b0;
    end else if (susp && sel) begin
      e = 8'h80;
      e[6] = n6[0];
      e[2] = n2[0];
    end
    if (run) n6++;
    if (sel && (susp || (run && op_erase))) n2++;
    @(posedge clk);
    #1;
    exp_q = e;
    tag = t;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rd_stb = 0;
    tag = "R2 hold";
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rd_data, 8'h00, "R1 reset value");
    mon_on = 1;
    idle(2);

    array_data = 8'h5A;
    rd(0, "R3 idle passthrough");
    array_data = 8'hC3;
    rd(5, "R3 idle passthrough 2");
    idle(2);

    busy = 1; op_erase = 0; tgt_data = 8'h80;
    rd(1, "R4 R6 R1 first program read");
    rd(1, "R4 R6 program toggle");
    tgt_data = 8'h00;
    rd(3, "R4 R11 program complement");
    over_time = 1;
    rd(3, "R7 over time");
    over_time = 0;
    idle(1);
    busy = 0; array_data = 8'h81;
    rd(1, "R3 after program");
    idle(1);

    busy = 1; op_erase = 1; sect_sel = 8'b0010_0100; accept_open = 1;
    rd(2, "R5 R8 R9 window open");
    accept_open = 0;
    rd(2, "R8 R9 window closed");
    rd(0, "R9 unselected hold");
    rd(5, "R9 selected toggle");
    rd(7, "R9 R6 unselected");
    idle(1);

    busy = 0; susp = 1; array_data = 8'h3C;
    rd(2, "R10 suspend selected");
    rd(2, "R10 R9 suspend toggle");
    rd(4, "R10 suspend unselected");
    idle(1);

    susp = 0; busy = 1;
    rd(5, "R5 R6 resumed erase");
    idle(1);
    busy = 0; array_data = 8'hFF;
    rd(5, "R3 erase done");
    idle(3);

    mon_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule